// File: doc/BRIEF.md
# Serial Page-Buffer Flash Command Engine

This block is the device side of a small serial flash. It sits behind a four-wire slave port (chip select, serial clock, serial data in and serial data out). A host lowers chip select, clocks in an 8-bit opcode, then the address bits, and then any data bytes. The block handles three commands: a page program that goes through a one-page byte buffer, an automatic rewrite of one page, and a read of the status byte.

Programming only starts when chip select rises. The block then runs a self-timed busy period. During that period the selected page is first erased to all ones and then loaded from the buffer. A rewrite first copies the page into the buffer and then programs it back. A host can poll the status byte throughout. If it stops the serial clock once the ready bit has been shifted out, data out follows the ready flag live.

All port pins are sampled with the system clock. The main array is an internal register RAM. The rest of the chip reads it through a plain combinational port.

Top module: `pgf_flash_engine`

## Requirements
- R1: After reset every array byte reads 0xFF, the block is ready, and `so` is high impedance while `cs_n` is high.
- R2: Opcode 0x82 is followed by 24 address bits, sent MSB first. The top 6 bits are reserved. Bits 17..9 form the page field, and only its low log2(NUM_PAGES) bits are used. Bits 8..0 form the buffer start offset, and only its low log2(PAGE_BYTES) bits are used.
- R3: Each complete data byte after the 0x82 address is stored at the buffer pointer. The pointer then advances, and it wraps from PAGE_BYTES-1 back to 0. A partial byte at chip-select rise is dropped.
- R4: When `cs_n` rises after a complete 0x82 address, the selected page is first erased to 0xFF. Every byte of the page is then replaced by the matching buffer byte. Bytes never written in this command keep their earlier buffer value.
- R5: Opcode 0x58 carries 24 address bits laid out as in R2, with the low 9 bits ignored. When `cs_n` rises, the page is copied into the buffer and then programmed back. Afterwards the buffer equals that page and the page is unchanged.
- R6: After opcode 0x57, each falling edge of `sck` presents the next status bit on `so`, MSB first, starting at bit 7. After bit 0 the sequence restarts at bit 7 for as long as `cs_n` stays low.
- R7: The status byte is {ready, DEV_INFO, 3'b000}, which is 0x98 when ready and 0x18 when busy with the default DEV_INFO of 4'b0011. Bit 7 is live: while bit 7 is on `so` and `sck` is held, `so` follows the ready flag.
- R8: A program or rewrite keeps the block busy for TEP system clocks, counted from the cycle after the synchronised chip-select rise.
- R9: While busy, any opcode other than 0x57 is ignored. No buffer byte is written and no new cycle starts.
- R10: If `cs_n` rises before all 24 address bits of 0x82 or 0x58 have arrived, the command is dropped and the block stays ready.
- R11: `si` is sampled on rising `sck` and `so` changes only after falling `sck`. All pins pass through a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select of the serial port |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, high impedance while `cs_n` is high |
| rd_page | input | log2(NUM_PAGES) | Page index for the array read port |
| rd_byte | input | log2(PAGE_BYTES) | Byte index for the array read port |
| rd_data | output | 8 | Array byte at `rd_page`/`rd_byte` |

## Verification
Program commands are driven from a table:
- A full page from offset 0.
- A short run whose page and offset fields carry bits above the used width, to check how the address fields are decoded.
- A run that crosses the top of the buffer and wraps to 0.
- A run with no data bytes, which programs the page from the leftover buffer.
- A run longer than the page, where the wrapped bytes overwrite earlier ones.

Directed tests then check the following:
- A program opcode sent while busy is ignored.
- Repeated status bytes read 0x18 during the busy period.
- The number of clocks until a held ready bit turns to 1 matches TEP.
- A rewrite changes the buffer but leaves its page as it was.
- A truncated address starts no busy period.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

  localparam logic [7:0] OP_PROG = 8'h82;
  localparam logic [7:0] OP_REWR = 8'h58;
  localparam logic [7:0] OP_STAT = 8'h57;
  localparam int         ADDR_BITS = 24;

  typedef enum logic [2:0] {
    D_IDLE, D_OPC, D_ADDR, D_DATA, D_ARM, D_STAT, D_IGN
  } dec_st_t;

  typedef enum logic [2:0] {
    E_IDLE, E_COPY, E_ERASE, E_PROG, E_HOLD
  } eng_st_t;

  // page field of a 24-bit address word
  function automatic logic [8:0] page_field(input logic [23:0] a);
    return a[17:9];
  endfunction

  // buffer start offset of a 24-bit address word
  function automatic logic [8:0] offs_field(input logic [23:0] a);
    return a[8:0];
  endfunction

  function automatic logic [7:0] status_byte(input logic ready, input logic [3:0] info);
    return {ready, info, 3'b000};
  endfunction

endpackage

// File: rtl/pgf_pinsync.sv
module pgf_pinsync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_low,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s
);
  logic [2:0] cs_q;
  logic [2:0] sk_q;
  logic [1:0] si_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 3'b111;
      sk_q <= 3'b000;
      si_q <= 2'b00;
    end else begin
      cs_q <= {cs_q[1:0], cs_n};
      sk_q <= {sk_q[1:0], sck};
      si_q <= {si_q[0], si};
    end
  end

  assign cs_low   = ~cs_q[1];
  assign cs_fall  = ~cs_q[1] &  cs_q[2];
  assign cs_rise  =  cs_q[1] & ~cs_q[2];
  assign sck_rise =  sk_q[1] & ~sk_q[2];
  assign sck_fall = ~sk_q[1] &  sk_q[2];
  assign si_s     =  si_q[1];

endmodule

// File: rtl/pgf_store.sv
module pgf_store #(
  parameter int PG_W = 3,
  parameter int BY_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  // host-side buffer write
  input  logic            hw_we,
  input  logic [BY_W-1:0] hw_idx,
  input  logic [7:0]      hw_dat,
  // engine-side buffer write (wins over host)
  input  logic            ew_we,
  input  logic [BY_W-1:0] ew_idx,
  input  logic [7:0]      ew_dat,
  // engine-side array write
  input  logic            mw_we,
  input  logic [PG_W-1:0] mw_page,
  input  logic [BY_W-1:0] mw_idx,
  input  logic [7:0]      mw_dat,
  // reads
  input  logic [BY_W-1:0] rb_idx,
  output logic [7:0]      rb_dat,
  input  logic [PG_W-1:0] rm_page,
  input  logic [BY_W-1:0] rm_idx,
  output logic [7:0]      rm_dat,
  input  logic [PG_W-1:0] xp_page,
  input  logic [BY_W-1:0] xp_idx,
  output logic [7:0]      xp_dat
);
  localparam int PB    = 1 << BY_W;
  localparam int DEPTH = (1 << PG_W) * PB;

  logic [7:0] bufm [PB];
  logic [7:0] arr  [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PB; i++) bufm[i] <= 8'hFF;
    end else if (ew_we) begin
      bufm[ew_idx] <= ew_dat;
    end else if (hw_we) begin
      bufm[hw_idx] <= hw_dat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) arr[i] <= 8'hFF;
    end else if (mw_we) begin
      arr[{mw_page, mw_idx}] <= mw_dat;
    end
  end

  assign rb_dat = bufm[rb_idx];
  assign rm_dat = arr[{rm_page, rm_idx}];
  assign xp_dat = arr[{xp_page, xp_idx}];

endmodule

// File: rtl/pgf_engine.sv
module pgf_engine
  import pgf_pkg::*;
#(
  parameter int PG_W = 3,
  parameter int BY_W = 4,
  parameter int TEP  = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_prog,
  input  logic            start_rw,
  input  logic [PG_W-1:0] page_in,
  output logic            busy,
  output logic [BY_W-1:0] rb_idx,
  input  logic [7:0]      rb_dat,
  output logic [PG_W-1:0] rm_page,
  output logic [BY_W-1:0] rm_idx,
  input  logic [7:0]      rm_dat,
  output logic            bw_we,
  output logic [BY_W-1:0] bw_idx,
  output logic [7:0]      bw_dat,
  output logic            mw_we,
  output logic [PG_W-1:0] mw_page,
  output logic [BY_W-1:0] mw_idx,
  output logic [7:0]      mw_dat
);
  // TEP must cover 3*2**BY_W stepping cycles; a shorter value stretches busy.
  localparam int TW = $clog2(TEP + 1);

  eng_st_t         ph;
  logic [BY_W-1:0] idx;
  logic [PG_W-1:0] page_q;
  logic [TW-1:0]   tcnt;
  logic            last;

  assign busy    = (ph != E_IDLE);
  assign last    = (idx == {BY_W{1'b1}});
  assign rb_idx  = idx;
  assign rm_page = page_q;
  assign rm_idx  = idx;
  assign bw_we   = (ph == E_COPY);
  assign bw_idx  = idx;
  assign bw_dat  = rm_dat;
  assign mw_we   = (ph == E_ERASE) || (ph == E_PROG);
  assign mw_page = page_q;
  assign mw_idx  = idx;
  assign mw_dat  = (ph == E_ERASE) ? 8'hFF : rb_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= E_IDLE;
      idx    <= '0;
      page_q <= '0;
      tcnt   <= '0;
    end else if (ph == E_IDLE) begin
      tcnt <= '0;
      idx  <= '0;
      if (start_prog) begin
        ph     <= E_ERASE;
        page_q <= page_in;
      end else if (start_rw) begin
        ph     <= E_COPY;
        page_q <= page_in;
      end
    end else begin
      tcnt <= tcnt + 1'b1;
      unique case (ph)
        E_COPY: begin
          idx <= idx + 1'b1;
          if (last) ph <= E_ERASE;
        end
        E_ERASE: begin
          idx <= idx + 1'b1;
          if (last) ph <= E_PROG;
        end
        E_PROG: begin
          idx <= idx + 1'b1;
          if (last) ph <= E_HOLD;
        end
        E_HOLD: if (tcnt >= TW'(TEP - 1)) ph <= E_IDLE;
        default: ph <= E_IDLE;
      endcase
    end
  end

  // R4: every byte is already erased when the program step overwrites it
  a_r4_erased_before_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == E_PROG) |-> (rm_dat == 8'hFF));

  // R9: the decoder never launches a cycle while one is running
  a_r9_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_rw) |-> (ph == E_IDLE));

endmodule

// File: rtl/pgf_decoder.sv
module pgf_decoder
  import pgf_pkg::*;
#(
  parameter int         PG_W     = 3,
  parameter int         BY_W     = 4,
  parameter logic [3:0] DEV_INFO = 4'b0011
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_low,
  input  logic            cs_fall,
  input  logic            cs_rise,
  input  logic            sck_rise,
  input  logic            sck_fall,
  input  logic            si_s,
  input  logic            busy,
  output logic            buf_we,
  output logic [BY_W-1:0] buf_idx,
  output logic [7:0]      buf_dat,
  output logic            start_prog,
  output logic            start_rw,
  output logic [PG_W-1:0] tgt_page,
  output logic            addr_pending,
  output logic            so_bit
);
  dec_st_t         st;
  logic [4:0]      cnt;
  logic [7:0]      sh;
  logic [7:0]      op;
  logic [23:0]     addr;
  logic [BY_W-1:0] ptr;
  logic [PG_W-1:0] page_q;
  logic            stat_on;
  logic [2:0]      sh_idx;
  logic [7:0]      sh_nx;
  logic [23:0]     addr_nx;
  logic [8:0]      pf_nx;
  logic [8:0]      of_nx;
  logic [7:0]      stat;

  assign sh_nx   = {sh[6:0], si_s};
  assign addr_nx = {addr[22:0], si_s};
  assign pf_nx   = page_field(addr_nx);
  assign of_nx   = offs_field(addr_nx);
  assign stat    = status_byte(!busy, DEV_INFO);

  assign start_prog   = cs_rise && (st == D_DATA);
  assign start_rw     = cs_rise && (st == D_ARM);
  assign tgt_page     = page_q;
  assign addr_pending = (st == D_ADDR) || (st == D_OPC);
  assign buf_we       = sck_rise && cs_low && (st == D_DATA) && (cnt[2:0] == 3'd7);
  assign buf_idx      = ptr;
  assign buf_dat      = sh_nx;
  assign so_bit       = stat_on ? stat[sh_idx] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= D_IDLE;
      cnt     <= '0;
      sh      <= '0;
      op      <= '0;
      addr    <= '0;
      ptr     <= '0;
      page_q  <= '0;
      stat_on <= 1'b0;
      sh_idx  <= 3'd7;
    end else if (!cs_low) begin
      st      <= D_IDLE;
      stat_on <= 1'b0;
    end else if (cs_fall) begin
      st      <= D_OPC;
      cnt     <= '0;
      stat_on <= 1'b0;
    end else begin
      if (sck_rise) begin
        sh  <= sh_nx;
        cnt <= cnt + 1'b1;
        unique case (st)
          D_OPC: if (cnt == 5'd7) begin
            cnt <= '0;
            op  <= sh_nx;
            if (sh_nx == OP_STAT)                        st <= D_STAT;
            else if (busy)                               st <= D_IGN;
            else if (sh_nx == OP_PROG || sh_nx == OP_REWR) st <= D_ADDR;
            else                                         st <= D_IGN;
          end
          D_ADDR: begin
            addr <= addr_nx;
            if (cnt == 5'd23) begin
              cnt    <= '0;
              page_q <= pf_nx[PG_W-1:0];
              ptr    <= of_nx[BY_W-1:0];
              st     <= (op == OP_PROG) ? D_DATA : D_ARM;
            end
          end
          D_DATA: if (cnt[2:0] == 3'd7) ptr <= ptr + 1'b1;
          default: ;
        endcase
      end
      if (sck_fall && st == D_STAT) begin
        if (!stat_on) begin
          stat_on <= 1'b1;
          sh_idx  <= 3'd7;
        end else begin
          sh_idx  <= sh_idx - 1'b1;
        end
      end
    end
  end

  // R3: each stored byte advances the pointer by one, modulo the page size
  a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> (ptr == BY_W'($past(ptr) + 1'b1)));

  // R6: after bit 0 the status stream returns to bit 7
  a_r6_status_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low && !cs_fall && sck_fall && st == D_STAT && stat_on && sh_idx == 3'd0)
      |=> (sh_idx == 3'd7));

endmodule

// File: rtl/pgf_flash_engine.sv
module pgf_flash_engine
  import pgf_pkg::*;
#(
  parameter int         NUM_PAGES  = 8,
  parameter int         PAGE_BYTES = 16,
  parameter int         TEP        = 1000,
  parameter logic [3:0] DEV_INFO   = 4'b0011,
  localparam int        PG_W       = $clog2(NUM_PAGES),
  localparam int        BY_W       = $clog2(PAGE_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            sck,
  input  logic            si,
  output logic            so,
  input  logic [PG_W-1:0] rd_page,
  input  logic [BY_W-1:0] rd_byte,
  output logic [7:0]      rd_data
);
  logic cs_low, cs_fall, cs_rise, sck_rise, sck_fall, si_s;
  logic busy, start_prog, start_rw, addr_pending, so_bit;
  logic            hw_we;
  logic [BY_W-1:0] hw_idx;
  logic [7:0]      hw_dat;
  logic [PG_W-1:0] tgt_page;
  logic [BY_W-1:0] rb_idx, rm_idx, bw_idx, mw_idx;
  logic [7:0]      rb_dat, rm_dat, bw_dat, mw_dat;
  logic [PG_W-1:0] rm_page, mw_page;
  logic            bw_we, mw_we;

  pgf_pinsync u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .cs_low(cs_low), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s)
  );

  pgf_decoder #(.PG_W(PG_W), .BY_W(BY_W), .DEV_INFO(DEV_INFO)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s),
    .busy(busy), .buf_we(hw_we), .buf_idx(hw_idx), .buf_dat(hw_dat),
    .start_prog(start_prog), .start_rw(start_rw), .tgt_page(tgt_page),
    .addr_pending(addr_pending), .so_bit(so_bit)
  );

  pgf_engine #(.PG_W(PG_W), .BY_W(BY_W), .TEP(TEP)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_rw(start_rw),
    .page_in(tgt_page), .busy(busy),
    .rb_idx(rb_idx), .rb_dat(rb_dat),
    .rm_page(rm_page), .rm_idx(rm_idx), .rm_dat(rm_dat),
    .bw_we(bw_we), .bw_idx(bw_idx), .bw_dat(bw_dat),
    .mw_we(mw_we), .mw_page(mw_page), .mw_idx(mw_idx), .mw_dat(mw_dat)
  );

  pgf_store #(.PG_W(PG_W), .BY_W(BY_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .hw_we(hw_we), .hw_idx(hw_idx), .hw_dat(hw_dat),
    .ew_we(bw_we), .ew_idx(bw_idx), .ew_dat(bw_dat),
    .mw_we(mw_we), .mw_page(mw_page), .mw_idx(mw_idx), .mw_dat(mw_dat),
    .rb_idx(rb_idx), .rb_dat(rb_dat),
    .rm_page(rm_page), .rm_idx(rm_idx), .rm_dat(rm_dat),
    .xp_page(rd_page), .xp_idx(rd_byte), .xp_dat(rd_data)
  );

  assign so = cs_n ? 1'bz : so_bit;

  // R10: a chip-select rise with the address still incomplete starts nothing
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && addr_pending && !busy) |=> !busy);

  // R9: host buffer writes never happen during a busy period
  a_r9_no_host_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !hw_we);

endmodule

// File: tb/tb_pgf_flash_engine.sv
`timescale 1ns/1ps
module tb_pgf_flash_engine;
  localparam int NP   = 8;
  localparam int PB   = 16;
  localparam int TEP  = 1000;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       si = 1'b0;
  wire        so;
  logic [2:0] rd_page = '0;
  logic [3:0] rd_byte = '0;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] m_mem [NP*PB];
  logic [7:0] m_buf [PB];

  // page(8) offset(8) count(8) seed(8)
  localparam logic [31:0] VEC [5] = '{
    {8'h00, 8'h00, 8'd16, 8'h10},
    {8'h0B, 8'h15, 8'd4,  8'hA0},
    {8'h07, 8'h0E, 8'd5,  8'h30},
    {8'h01, 8'h00, 8'd0,  8'h00},
    {8'h02, 8'h03, 8'd20, 8'h50}
  };

  pgf_flash_engine #(.NUM_PAGES(NP), .PAGE_BYTES(PB), .TEP(TEP)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so),
    .rd_page(rd_page), .rd_byte(rd_byte), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      si = b[i]; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
    end
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(HALF); b[i] = so; sck = 1'b1; tick(HALF); sck = 1'b0;
    end
  endtask

  task automatic cs_begin();
    cs_n = 1'b0; tick(4);
  endtask

  task automatic cs_end();
    tick(4); cs_n = 1'b1; tick(4);
  endtask

  task automatic send_addr(input logic [8:0] pg, input logic [8:0] off);
    logic [23:0] a;
    a = {6'b0, pg, off};
    send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
  endtask

  // program command; model is updated only when the command should be taken
  task automatic prog_cmd(input logic [8:0] pg, input logic [8:0] off,
                          input int n, input logic [7:0] seed, input bit taken);
    int p;
    p = int'(off[3:0]);
    cs_begin();
    send_byte(8'h82);
    send_addr(pg, off);
    for (int k = 0; k < n; k++) begin
      send_byte(seed + 8'(k));
      if (taken) m_buf[p] = seed + 8'(k);
      p = (p + 1) % PB;
    end
    cs_end();
    if (taken)
      for (int i = 0; i < PB; i++) m_mem[int'(pg[2:0])*PB + i] = m_buf[i];
  endtask

  task automatic page_check(input string req, input int pg);
    for (int i = 0; i < PB; i++) begin
      rd_page = 3'(pg); rd_byte = 4'(i); tick(1);
      chk(req, rd_data, m_mem[pg*PB + i]);
    end
  endtask

  task automatic read_status(input int nbytes, input string req, input logic [7:0] exp);
    logic [7:0] b;
    cs_begin();
    send_byte(8'h57);
    for (int k = 0; k < nbytes; k++) begin
      recv_byte(b);
      chk(req, b, exp);
    end
    cs_end();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    realtime t0;
    int el;
    for (int i = 0; i < NP*PB; i++) m_mem[i] = 8'hFF;
    for (int i = 0; i < PB; i++) m_buf[i] = 8'hFF;
    tick(5); rst_n = 1'b1; tick(5);

    // R1 / R11 reset state
    chk("R1 so hi-z", {7'b0, so === 1'bz}, 8'h01);
    page_check("R1 erased", 0);
    page_check("R1 erased", 5);
    // R6 / R7 two ready bytes in a row
    read_status(2, "R6 R7 ready status", 8'h98);
    chk("R11 so hi-z after cs", {7'b0, so === 1'bz}, 8'h01);

    // table of program commands: R2 field decode, R3 wrap, R4 page update
    for (int v = 0; v < 5; v++) begin
      logic [31:0] e;
      e = VEC[v];
      prog_cmd({1'b0, e[31:24]}, {1'b0, e[23:16]}, int'(e[15:8]), e[7:0], 1'b1);
      tick(TEP + 20);
      page_check("R2 R3 R4 program", int'(e[26:24]));
    end

    // R8 / R9 busy period: ignored program, then status bytes read busy
    prog_cmd(9'd4, 9'd0, 1, 8'h77, 1'b1);
    prog_cmd(9'd5, 9'd0, 2, 8'h00, 1'b0);
    read_status(2, "R8 R7 busy status", 8'h18);
    tick(TEP);
    page_check("R9 ignored while busy", 5);
    page_check("R4 program", 4);

    // R7 / R8 live ready bit, busy length measured in clocks
    cs_begin();
    send_byte(8'h82);
    send_addr(9'd6, 9'd0);
    tick(4);
    cs_n = 1'b1;
    t0 = $realtime;
    for (int i = 0; i < PB; i++) m_mem[6*PB + i] = m_buf[i];
    tick(4);
    cs_begin();
    send_byte(8'h57);
    tick(2);
    chk("R7 live bit busy", {7'b0, so}, 8'h00);
    el = 0;
    while (so !== 1'b1 && el < 3000) begin
      tick(1);
      el = int'(($realtime - t0) / 20.0);
    end
    chk("R8 busy length lower", {7'b0, el >= TEP + 2}, 8'h01);
    chk("R8 busy length upper", {7'b0, el <= TEP + 4}, 8'h01);
    cs_end();
    page_check("R4 program", 6);

    // R5 rewrite of page 0 with non-zero don't-care bits
    cs_begin();
    send_byte(8'h58);
    send_addr(9'd0, 9'h1A5);
    cs_end();
    for (int i = 0; i < PB; i++) m_buf[i] = m_mem[i];
    tick(TEP + 20);
    page_check("R5 rewrite keeps page", 0);
    prog_cmd(9'd3, 9'd0, 0, 8'h00, 1'b1);
    tick(TEP + 20);
    page_check("R5 rewrite loads buffer", 3);

    // R10 truncated addresses
    cs_begin();
    send_byte(8'h82);
    send_byte(8'h00);
    cs_end();
    read_status(1, "R10 abort stays ready", 8'h98);
    cs_begin();
    send_byte(8'h58);
    send_byte(8'h00);
    send_byte(8'h02);
    cs_end();
    read_status(1, "R10 abort stays ready", 8'h98);
    page_check("R10 page untouched", 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule